// File: doc/BRIEF.md
# JTAG Data Register Bank

This block is the data-register half of a test access port. A TAP state machine and an instruction register sit outside it. The state machine supplies one-hot capture, shift and update strobes for the data-register column. The instruction register supplies the current opcode. The opcode decides which register sits between TDI and TDO. The choices are a single-bit bypass stage, a 32-bit identification register holding a fixed device code, and a parameterised number of user data registers.

Each user data register has two parts: a serial shift stage and a parallel hold stage. The hold stage drives the JTAG write port of a small internal functional register. Core logic can write and read that same register through a second port. A debugger can therefore see the current contents of the register, shift in a new value without disturbing it, and commit the new value with one update.

All state advances on the rising edge of TCK. TDO is retimed on the falling edge. Any opcode the block does not recognise falls back to the bypass path, so a chain of devices always keeps a known length.

Top module: `jtag_dr_bank`

## Requirements
- R1: While `rst_n` is low, `tdo` reads 0 and every functional register reads `UDR_RST`. The default for `UDR_RST` is 0.
- R2: Only the register that the opcode selects captures, shifts or commits. Scans on other paths leave every functional register unchanged.
- R3: The block decodes these opcodes: `OP_IDCODE` (default 4'h1) selects the ID register, and `OP_USER_BASE + k` (default 4'h8 + k) selects user register k. `OP_BYPASS` (default 4'hF) and every other value select the bypass stage.
- R4: The bypass stage captures 0 and then delays TDI by exactly one TCK cycle. Shifting byte B through it therefore returns `{B[6:0],0}`.
- R5: On capture, the ID register loads `ID_CODE`, whose bit 0 must be 1 (default 32'h5A3C_9E15). A 32-bit shift then returns that code.
- R6: Shifting moves one bit per rising edge, from MSB toward LSB, with TDI entering at the MSB. `tdo` presents bit 0 of the selected stage and changes only on a falling edge. The first bit out is captured bit 0.
- R7: On capture, a selected user shift stage loads the present value of its functional register.
- R8: Capture and shift leave the hold stage unchanged. Update-DR copies the selected shift stage into its hold stage. The functional register takes the hold value on the following rising edge.
- R9: When `func_we[k]` is high, functional register k loads slice k of `func_wdata` on the rising edge. Its value always appears on slice k of `func_rdata`. Slice k occupies bits `[k*UDR_W +: UDR_W]`.
- R10: A JTAG commit and a functional write that reach the same register on the same edge resolve in favour of the JTAG value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; also clocks the functional registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial test data in |
| instr | input | IR_W | Current opcode from the instruction register |
| cap_dr | input | 1 | Capture-DR state strobe |
| shf_dr | input | 1 | Shift-DR state strobe |
| upd_dr | input | 1 | Update-DR state strobe |
| func_we | input | NUM_USER | Per-register functional write enable |
| func_wdata | input | NUM_USER*UDR_W | Functional write data, slice per register |
| func_rdata | output | NUM_USER*UDR_W | Functional register contents, slice per register |
| tdo | output | 1 | Serial test data out, falling-edge timed |

## Verification
The bench uses the default parameters: a 4-bit opcode, two 8-bit user registers and a 32-bit identification code. A byte of asymmetric pattern exposes any reversal of bit order or any off-by-one in the bypass delay. A second user register shows whether a scan leaks into a register that is not selected. With a 4-bit opcode the bench can reach unused codes both below and above the user range, and it drives a functional write and a JTAG commit onto the same edge.

// File: rtl/jtag_dr_pkg.sv
package jtag_dr_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Which data-register path currently sits between TDI and TDO
   typedef enum logic [1:0] {
      DR_BYPASS = 2'd0,
      DR_IDCODE = 2'd1,
      DR_USER   = 2'd2
   } dr_path_e;

   // State strobes from the TAP controller, at most one set per cycle
   typedef struct packed {
      logic capture;
      logic shift;
      logic update;
   } dr_strobe_t;
endpackage

// File: rtl/jtag_dr_decode.sv
module jtag_dr_decode
   import jtag_dr_pkg::*;
#(
   parameter int IR_W         = 4,
   parameter int NUM_USER     = 2,
   parameter int OP_IDCODE    = 1,
   parameter int OP_USER_BASE = 8
) (
   input  logic [IR_W-1:0]     instr,
   output dr_path_e            path,
   output logic [NUM_USER-1:0] user_sel
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [IR_W-1:0] ID_OP = IR_W'(OP_IDCODE);

   // Anything not matched below falls back to bypass
   always_comb begin
      path     = DR_BYPASS;
      user_sel = '0;
      if (instr == ID_OP) begin
         path = DR_IDCODE;
      end
      for (int k = 0; k < NUM_USER; k++) begin
         if (instr == IR_W'(OP_USER_BASE + k)) begin
            path        = DR_USER;
            user_sel[k] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/jtag_dr_shift.sv
module jtag_dr_shift #(
   parameter int           W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         tck,
   input  logic         rst_n,
   input  logic         cap_en,
   input  logic         shf_en,
   input  logic [W-1:0] cap_val,
   input  logic         tdi,
   output logic [W-1:0] q
);
   timeunit 1ns;
   timeprecision 1ps;

   generate
      if (W == 1) begin : g_bit
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n)      q <= RST;
            else if (cap_en) q <= cap_val;
            else if (shf_en) q <= tdi;
         end
      end else begin : g_vec
         // TDI enters at the MSB, bit 0 leaves toward TDO
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n)      q <= RST;
            else if (cap_en) q <= cap_val;
            else if (shf_en) q <= {tdi, q[W-1:1]};
         end
      end
   endgenerate
endmodule

// File: rtl/jtag_dr_user.sv
module jtag_dr_user
   import jtag_dr_pkg::*;
#(
   parameter int           W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         tck,
   input  logic         rst_n,
   input  logic         sel,
   input  dr_strobe_t   strobe,
   input  logic         tdi,
   input  logic         func_we,
   input  logic [W-1:0] func_wdata,
   output logic [W-1:0] func_q,
   output logic [W-1:0] shift_q,
   output logic [W-1:0] hold_q,
   output logic         commit
);
   timeunit 1ns;
   timeprecision 1ps;

   logic cap_en, shf_en, upd_en;

   assign cap_en = sel & strobe.capture;
   assign shf_en = sel & strobe.shift;
   assign upd_en = sel & strobe.update;

   jtag_dr_shift #(.W(W), .RST(RST)) u_shift (
      .tck     (tck),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .shf_en  (shf_en),
      .cap_val (func_q),
      .tdi     (tdi),
      .q       (shift_q)
   );

   // Hold stage: only update-DR touches it
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      hold_q <= RST;
      else if (upd_en) hold_q <= shift_q;
   end

   // One-cycle commit pulse drives the JTAG port of the functional register
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) commit <= 1'b0;
      else        commit <= upd_en;
   end

   // Dual-access functional register, JTAG port wins a collision
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)       func_q <= RST;
      else if (commit)  func_q <= hold_q;
      else if (func_we) func_q <= func_wdata;
   end
endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
   import jtag_dr_pkg::*;
#(
   parameter int               IR_W         = 4,
   parameter int               UDR_W        = 8,
   parameter int               NUM_USER     = 2,
   parameter logic [31:0]      ID_CODE      = 32'h5A3C_9E15,
   parameter int               OP_IDCODE    = 1,
   parameter int               OP_BYPASS    = 15,
   parameter int               OP_USER_BASE = 8,
   parameter logic [UDR_W-1:0] UDR_RST      = '0
) (
   input  logic                      tck,
   input  logic                      rst_n,
   input  logic                      tdi,
   input  logic [IR_W-1:0]           instr,
   input  logic                      cap_dr,
   input  logic                      shf_dr,
   input  logic                      upd_dr,
   input  logic [NUM_USER-1:0]       func_we,
   input  logic [NUM_USER*UDR_W-1:0] func_wdata,
   output logic [NUM_USER*UDR_W-1:0] func_rdata,
   output logic                      tdo
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int ID_W     = 32;
   localparam int OP_SPACE = 2 ** IR_W;
   localparam int USER_TOP = OP_USER_BASE + NUM_USER - 1;

   // Elaboration-time parameter checks
   if (IR_W < 2) begin : g_chk_ir
      $error("IR_W must be at least 2");
   end
   if (NUM_USER < 1) begin : g_chk_num
      $error("NUM_USER must be at least 1");
   end
   if (UDR_W < 2) begin : g_chk_w
      $error("UDR_W must be at least 2");
   end
   if (ID_CODE[0] != 1'b1) begin : g_chk_id
      $error("ID_CODE bit 0 must be 1");
   end
   if (USER_TOP >= OP_SPACE || OP_IDCODE >= OP_SPACE || OP_BYPASS >= OP_SPACE) begin : g_chk_range
      $error("opcode outside instruction width");
   end
   if (OP_IDCODE == OP_BYPASS) begin : g_chk_dup
      $error("ID and bypass opcodes collide");
   end
   if (OP_IDCODE >= OP_USER_BASE && OP_IDCODE <= USER_TOP) begin : g_chk_id_usr
      $error("ID opcode falls in user range");
   end
   if (OP_BYPASS >= OP_USER_BASE && OP_BYPASS <= USER_TOP) begin : g_chk_byp_usr
      $error("bypass opcode falls in user range");
   end

   dr_path_e                        path;
   logic [NUM_USER-1:0]             user_sel;
   dr_strobe_t                      strobe;
   logic [0:0]                      byp_q;
   logic [ID_W-1:0]                 id_q;
   logic [NUM_USER-1:0][UDR_W-1:0]  shift_all;
   logic [NUM_USER-1:0][UDR_W-1:0]  hold_all;
   logic [NUM_USER-1:0][UDR_W-1:0]  func_all;
   logic [NUM_USER-1:0]             commit;
   logic [NUM_USER-1:0]             usr_lsb;
   logic                            tdo_d;

   assign strobe = '{capture: cap_dr, shift: shf_dr, update: upd_dr};

   jtag_dr_decode #(
      .IR_W         (IR_W),
      .NUM_USER     (NUM_USER),
      .OP_IDCODE    (OP_IDCODE),
      .OP_USER_BASE (OP_USER_BASE)
   ) u_decode (
      .instr    (instr),
      .path     (path),
      .user_sel (user_sel)
   );

   jtag_dr_shift #(.W(1), .RST(1'b0)) u_bypass (
      .tck     (tck),
      .rst_n   (rst_n),
      .cap_en  (cap_dr & (path == DR_BYPASS)),
      .shf_en  (shf_dr & (path == DR_BYPASS)),
      .cap_val (1'b0),
      .tdi     (tdi),
      .q       (byp_q)
   );

   jtag_dr_shift #(.W(ID_W), .RST(ID_CODE)) u_idreg (
      .tck     (tck),
      .rst_n   (rst_n),
      .cap_en  (cap_dr & (path == DR_IDCODE)),
      .shf_en  (shf_dr & (path == DR_IDCODE)),
      .cap_val (ID_CODE),
      .tdi     (tdi),
      .q       (id_q)
   );

   for (genvar k = 0; k < NUM_USER; k++) begin : g_user
      jtag_dr_user #(.W(UDR_W), .RST(UDR_RST)) u_user (
         .tck        (tck),
         .rst_n      (rst_n),
         .sel        (user_sel[k]),
         .strobe     (strobe),
         .tdi        (tdi),
         .func_we    (func_we[k]),
         .func_wdata (func_wdata[k*UDR_W +: UDR_W]),
         .func_q     (func_all[k]),
         .shift_q    (shift_all[k]),
         .hold_q     (hold_all[k]),
         .commit     (commit[k])
      );
      assign usr_lsb[k] = user_sel[k] & shift_all[k][0];
   end

   assign func_rdata = func_all;

   always_comb begin
      case (path)
         DR_IDCODE: tdo_d = id_q[0];
         DR_USER:   tdo_d = |usr_lsb;
         default:   tdo_d = byp_q[0];
      endcase
   end

   // TDO retimed on the falling edge
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) tdo <= 1'b0;
      else        tdo <= tdo_d;
   end
endmodule

// File: rtl/jtag_dr_bank_chk.sv
module jtag_dr_bank_chk
   import jtag_dr_pkg::*;
#(
   parameter int          UDR_W    = 8,
   parameter int          NUM_USER = 2,
   parameter logic [31:0] ID_CODE  = 32'h5A3C_9E15
) (
   input logic                           tck,
   input logic                           rst_n,
   input logic                           tdi,
   input logic                           cap_dr,
   input logic                           shf_dr,
   input logic                           upd_dr,
   input logic [NUM_USER-1:0]            func_we,
   input logic [NUM_USER*UDR_W-1:0]      func_wdata,
   input logic [NUM_USER*UDR_W-1:0]      func_rdata,
   input dr_path_e                       path,
   input logic [0:0]                     byp_q,
   input logic [31:0]                    id_q,
   input logic [NUM_USER-1:0][UDR_W-1:0] hold_all,
   input logic [NUM_USER-1:0]            commit
);
   timeunit 1ns;
   timeprecision 1ps;

   AST_BYPASS_ZERO_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
      (cap_dr && path == DR_BYPASS) |=> (byp_q == 1'b0));  // R4
   AST_BYPASS_ONE_STAGE: assert property (@(posedge tck) disable iff (!rst_n)
      (shf_dr && path == DR_BYPASS) |=> (byp_q[0] == $past(tdi)));  // R4
   AST_ID_CAPTURE_CODE: assert property (@(posedge tck) disable iff (!rst_n)
      (cap_dr && path == DR_IDCODE) |=> (id_q == ID_CODE));  // R5
   AST_ID_IDLE_UNSELECTED: assert property (@(posedge tck) disable iff (!rst_n)
      (path != DR_IDCODE) |=> $stable(id_q));  // R2
   AST_HOLD_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
      !upd_dr |=> $stable(hold_all));  // R8

   for (genvar k = 0; k < NUM_USER; k++) begin : g_usr_chk
      AST_JTAG_COMMIT_WINS: assert property (@(posedge tck) disable iff (!rst_n)
         commit[k] |=> (func_rdata[k*UDR_W +: UDR_W] == $past(hold_all[k])));  // R10
      AST_FUNC_WRITE_LANDS: assert property (@(posedge tck) disable iff (!rst_n)
         (func_we[k] && !commit[k]) |=>
            (func_rdata[k*UDR_W +: UDR_W] == $past(func_wdata[k*UDR_W +: UDR_W])));  // R9
   end
endmodule

bind jtag_dr_bank jtag_dr_bank_chk #(
   .UDR_W    (UDR_W),
   .NUM_USER (NUM_USER),
   .ID_CODE  (ID_CODE)
) u_chk (
   .tck        (tck),
   .rst_n      (rst_n),
   .tdi        (tdi),
   .cap_dr     (cap_dr),
   .shf_dr     (shf_dr),
   .upd_dr     (upd_dr),
   .func_we    (func_we),
   .func_wdata (func_wdata),
   .func_rdata (func_rdata),
   .path       (path),
   .byp_q      (byp_q),
   .id_q       (id_q),
   .hold_all   (hold_all),
   .commit     (commit)
);

// File: tb/jtag_dr_bank_bench.sv
module jtag_dr_bank_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [31:0] IDC   = 32'h5A3C_9E15;
   localparam int          NVEC  = 9;

   typedef struct packed {
      logic [3:0]  op;
      logic [5:0]  nbits;
      logic [31:0] din;
      logic [31:0] dout;
      logic [7:0]  f0;
      logic [7:0]  f1;
   } vec_t;

   // Each row: scan with capture, shift and update, then check TDO stream and registers
   localparam vec_t VECS [0:NVEC-1] = '{
      '{4'h1, 6'd32, 32'hFFFF_0000, IDC,   8'h00, 8'h00},  // R5 ID readout
      '{4'hF, 6'd8,  32'h0000_00A5, 32'h4A, 8'h00, 8'h00},  // R4 bypass delay
      '{4'h5, 6'd8,  32'h0000_00A5, 32'h4A, 8'h00, 8'h00},  // R3 unknown low
      '{4'h9, 6'd8,  32'h0000_00C3, 32'h00, 8'h00, 8'hC3},  // R8 user1 write
      '{4'h8, 6'd8,  32'h0000_003C, 32'h00, 8'h3C, 8'hC3},  // R8 user0 write
      '{4'h8, 6'd8,  32'h0000_0081, 32'h3C, 8'h81, 8'hC3},  // R7 user0 readback
      '{4'h9, 6'd8,  32'h0000_0000, 32'hC3, 8'h81, 8'h00},  // R7 user1 readback
      '{4'hA, 6'd8,  32'h0000_0001, 32'h02, 8'h81, 8'h00},  // R3 unknown high
      '{4'h0, 6'd8,  32'h0000_0080, 32'h00, 8'h81, 8'h00}   // R3 unknown zero
   };

   logic        tck = 1'b0;
   logic        rst_n = 1'b0;
   logic        tdi = 1'b0;
   logic [3:0]  instr = 4'hF;
   logic        cap_dr = 1'b0, shf_dr = 1'b0, upd_dr = 1'b0;
   logic [1:0]  func_we = '0;
   logic [15:0] func_wdata = '0;
   logic [15:0] func_rdata;
   logic        tdo;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 tck = ~tck;  // 100 MHz

   jtag_dr_bank u_jtag_dr_bank (
      .tck        (tck),
      .rst_n      (rst_n),
      .tdi        (tdi),
      .instr      (instr),
      .cap_dr     (cap_dr),
      .shf_dr     (shf_dr),
      .upd_dr     (upd_dr),
      .func_we    (func_we),
      .func_wdata (func_wdata),
      .func_rdata (func_rdata),
      .tdo        (tdo)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // Called 2 ns after a rising edge; returns 2 ns after a rising edge
   task automatic scan(input logic [3:0] op, input int n, input logic [31:0] din,
                       input bit do_upd, output logic [31:0] dout);
      dout   = '0;
      instr  = op;
      cap_dr = 1'b1;
      @(posedge tck); #2;
      cap_dr = 1'b0;
      for (int i = 0; i < n; i++) begin
         shf_dr = 1'b1;
         tdi    = din[i];
         @(negedge tck); #2;
         dout[i] = tdo;
         @(posedge tck); #2;
      end
      shf_dr = 1'b0;
      tdi    = 1'b0;
      if (do_upd) begin
         upd_dr = 1'b1;
         @(posedge tck); #2;
         upd_dr = 1'b0;
         @(posedge tck); #2;
      end
   endtask

   initial begin
      #2_000_000;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

   initial begin
      logic [31:0] got;
      // R1: reset state
      @(posedge tck); #2;
      check("R1 tdo in reset", {31'b0, tdo}, 32'h0);
      check("R1 func in reset", {16'b0, func_rdata}, 32'h0);
      @(posedge tck); #2;
      rst_n = 1'b1;
      @(posedge tck); #2;
      check("R1 func after reset", {16'b0, func_rdata}, 32'h0);

      // Table walk
      for (int v = 0; v < NVEC; v++) begin
         scan(VECS[v].op, int'(VECS[v].nbits), VECS[v].din, 1'b1, got);
         check($sformatf("R6 tdo stream vec %0d", v), got, VECS[v].dout);
         check($sformatf("R2 func0 vec %0d", v), {24'b0, func_rdata[7:0]}, {24'b0, VECS[v].f0});
         check($sformatf("R2 func1 vec %0d", v), {24'b0, func_rdata[15:8]}, {24'b0, VECS[v].f1});
      end

      // R8: shift without update leaves the register alone
      scan(4'h8, 8, 32'hF0, 1'b0, got);
      check("R7 user0 capture", got, 32'h81);
      check("R8 no update keeps func0", {24'b0, func_rdata[7:0]}, 32'h81);
      // R8: lone update copies the shifted value
      instr  = 4'h8;
      upd_dr = 1'b1;
      @(posedge tck); #2;
      upd_dr = 1'b0;
      check("R8 func0 one cycle before commit", {24'b0, func_rdata[7:0]}, 32'h81);
      @(posedge tck); #2;
      check("R8 func0 after commit", {24'b0, func_rdata[7:0]}, 32'hF0);

      // R9: functional write, then JTAG capture sees it
      func_we    = 2'b10;
      func_wdata = 16'h7700;
      @(posedge tck); #2;
      func_we = '0;
      check("R9 func1 write", {24'b0, func_rdata[15:8]}, 32'h77);
      check("R9 func0 untouched", {24'b0, func_rdata[7:0]}, 32'hF0);
      scan(4'h9, 8, 32'h00, 1'b0, got);
      check("R7 capture of functional write", got, 32'h77);

      // R10: collision on user0
      scan(4'h8, 8, 32'h55, 1'b0, got);
      upd_dr = 1'b1;
      @(posedge tck); #2;
      upd_dr     = 1'b0;
      func_we    = 2'b01;
      func_wdata = 16'h00EE;
      @(posedge tck); #2;
      func_we = '0;
      check("R10 JTAG wins collision", {24'b0, func_rdata[7:0]}, 32'h55);
      check("R10 other register intact", {24'b0, func_rdata[15:8]}, 32'h77);

      // R4: bypass with all ones after a single zero
      scan(4'hF, 4, 32'hF, 1'b0, got);
      check("R4 bypass ones", got, 32'hE);

      // R1: asynchronous reset mid-run
      #1 rst_n = 1'b0;
      #3;
      check("R1 async reset func", {16'b0, func_rdata}, 32'h0);
      check("R1 async reset tdo", {31'b0, tdo}, 32'h0);

      finish_run();
   end
endmodule